// File: doc/BRIEF.md
# Hierarchical Single-Vector Interrupt Controller

This block gathers event pulses from a set of peripheral modules and from one group of system sources. Each event sets a sticky flag. A flag reaches the processor only when three gates are all open: the source's own enable (a per-source input driven by the peripheral), the mask bit of the module the source belongs to, and a global enable. When any flag passes all three gates, the block raises one interrupt request and presents one programmable vector address. Every source uses that same address.

Software finds the cause through identification registers. A top-level register has one bit per module, where the system group counts as one more module. Each module also has its own register, with one bit per source. Flags are cleared by writing ones. All module masks live in one register, so software can set the relative priority of modules with a single write. After the processor accepts a request, further requests are held off until it signals a return from interrupt.

Groups are numbered 0 to N_MOD-1 for the peripheral modules, and N_MOD is the system group. Source s of group g occupies bit g*N_SRC+s of `src_evt` and `src_en`.

Top module: `hier_int_ctrl`

## Requirements
- R1: After reset, every register below reads 0 and `irq_req` is low: the control word (address 0, bit 0 = global enable), the mask (address 1, bit g = group g), the vector (address 2, also driven on `irq_vec`), every flag and the top identification word (address 3).
- R2: A one-cycle pulse on a `src_evt` bit sets that source's flag. The flag is set even when the source's enable, its group mask and the global enable are all 0. The flags of group g read at address 16+g, with bit s = source s.
- R3: A flag stays set until software writes 1 to its bit at address 16+g. Writing 0 to a bit leaves it unchanged. If an event and a clear reach the same flag in the same cycle, the flag stays set.
- R4: `irq_req` rises exactly one clock after the first cycle in which some flag, its `src_en` bit, its group mask bit and the global enable are all 1. It falls one clock after no such source remains.
- R5: `irq_vec` always equals the vector register at address 2. A write to address 2 takes effect on the next cycle.
- R6: Bit g of the top identification word (address 3) is the OR over group g of (flag AND `src_en`). It does not depend on the mask or the global enable. Writes to address 3 are ignored.
- R7: The module identification word of group g, at address 8+g, has bit s = flag AND `src_en` for source s.
- R8: One write to address 1 can enable or disable several groups at once. A group whose mask bit is 0 cannot cause `irq_req`.
- R9: A `cpu_ack` pulse while `irq_req` is high forces `irq_req` low from the next cycle. It stays low regardless of events until a `cpu_reti` pulse. After that pulse, a source that is still enabled and pending raises `irq_req` again on the next cycle.
- R10: While the global enable is 0, `irq_req` stays low from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | (N_MOD+1)*N_SRC | Per-source event pulses |
| src_en | input | (N_MOD+1)*N_SRC | Per-source local enables from the peripherals |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on reg_addr) |
| cpu_ack | input | 1 | Processor accepts the pending request |
| cpu_reti | input | 1 | Processor returns from the interrupt routine |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | DATA_W | Shared interrupt vector address |

## Verification
The assertions assume two things about the processor side. First, `cpu_ack` is only pulsed while `irq_req` is high. Second, `cpu_ack` and `cpu_reti` never arrive in the same cycle. The directed tasks respect this: they pulse the acknowledge only after sampling the request high, and they issue the return as a separate pulse later. The assertions also assume register writes are single-cycle strobes with a stable address. The bench drives every input on the falling edge, so each write, event and handshake covers exactly one rising edge.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CTRL       = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASK       = 5'd1;
  localparam logic [ADDR_W-1:0] A_VEC        = 5'd2;
  localparam logic [ADDR_W-1:0] A_TOPID      = 5'd3;
  localparam logic [ADDR_W-1:0] A_MODID_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] A_FLAG_BASE  = 5'd16;
  localparam int MAX_GROUPS = 8;

  typedef enum logic {
    SVC_IDLE = 1'b0,
    SVC_BUSY = 1'b1
  } svc_e;
endpackage

// File: rtl/icu_flag_bank.sv
module icu_flag_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] en,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] pend,
  output logic             any_pend
);
  logic [N_SRC-1:0] flag_q, flag_d, clr_eff;
  logic             upd;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    // a fresh event has priority over a clear of the same bit
    flag_d  = (flag_q & ~clr_eff) | evt;
    upd     = clr_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (upd) begin
      flag_q <= flag_d;
    end
  end

  assign flags    = flag_q;
  assign pend     = flag_q & en;
  assign any_pend = |pend;
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int N_GRP  = 5,
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  localparam int TOT   = N_GRP * N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [TOT-1:0]    flags_all,
  input  logic [TOT-1:0]    pend_all,
  input  logic [N_GRP-1:0]  top_id,
  output logic              gie,
  output logic [N_GRP-1:0]  mask,
  output logic [DATA_W-1:0] vec,
  output logic [DATA_W-1:0] rdata
);
  logic              gie_q, gie_d, gie_ce;
  logic [N_GRP-1:0]  mask_q, mask_d;
  logic              mask_ce;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic              vec_ce;

  always_comb begin
    gie_ce  = reg_we && (reg_addr == A_CTRL);
    mask_ce = reg_we && (reg_addr == A_MASK);
    vec_ce  = reg_we && (reg_addr == A_VEC);
    gie_d   = reg_wdata[0];
    mask_d  = reg_wdata[N_GRP-1:0];
    vec_d   = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_ce) begin
      gie_q <= gie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_ce) begin
      vec_q <= vec_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_addr)
      A_CTRL:  rdata[0]         = gie_q;
      A_MASK:  rdata[N_GRP-1:0] = mask_q;
      A_VEC:   rdata            = vec_q;
      A_TOPID: rdata[N_GRP-1:0] = top_id;
      default: begin
        for (int g = 0; g < N_GRP; g++) begin
          if (reg_addr == A_MODID_BASE + ADDR_W'(g))
            rdata[N_SRC-1:0] = pend_all[g*N_SRC +: N_SRC];
          if (reg_addr == A_FLAG_BASE + ADDR_W'(g))
            rdata[N_SRC-1:0] = flags_all[g*N_SRC +: N_SRC];
        end
      end
    endcase
  end

  assign gie  = gie_q;
  assign mask = mask_q;
  assign vec  = vec_q;
endmodule

// File: rtl/icu_req.sv
module icu_req
  import icu_pkg::*;
#(
  parameter int N_GRP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gie,
  input  logic [N_GRP-1:0] mask,
  input  logic [N_GRP-1:0] top_id,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             irq_req,
  output logic             in_service
);
  svc_e svc_q, svc_d;
  logic irq_q, irq_d;
  logic deliver;

  always_comb begin
    deliver = gie && (|(mask & top_id));
    svc_d   = svc_q;
    if (svc_q == SVC_IDLE && cpu_ack && irq_q) svc_d = SVC_BUSY;
    if (cpu_reti)                              svc_d = SVC_IDLE;
    irq_d   = deliver && (svc_d == SVC_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= SVC_IDLE;
      irq_q <= 1'b0;
    end else begin
      svc_q <= svc_d;
      irq_q <= irq_d;
    end
  end

  assign irq_req    = irq_q;
  assign in_service = (svc_q == SVC_BUSY);
endmodule

// File: rtl/hier_int_ctrl.sv
module hier_int_ctrl
  import icu_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  localparam int N_GRP = N_MOD + 1,
  localparam int TOT   = N_GRP * N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOT-1:0]    src_evt,
  input  logic [TOT-1:0]    src_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_ack,
  input  logic              cpu_reti,
  output logic              irq_req,
  output logic [DATA_W-1:0] irq_vec
);
  initial begin
    if (N_GRP > MAX_GROUPS) $error("too many groups for the address map");
    if (N_SRC > DATA_W)     $error("sources per group exceed data width");
  end

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [TOT-1:0]   flags_all, pend_all;
  logic [N_GRP-1:0] top_id, mask;
  logic             gie, in_service;
  logic [DATA_W-1:0] vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic clr_we;
    assign clr_we = reg_we && (reg_addr == A_FLAG_BASE + ADDR_W'(g));
    icu_flag_bank #(.N_SRC(N_SRC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .evt      (src_evt[g*N_SRC +: N_SRC]),
      .en       (src_en[g*N_SRC +: N_SRC]),
      .clr_we   (clr_we),
      .clr_bits (reg_wdata[N_SRC-1:0]),
      .flags    (flags_all[g*N_SRC +: N_SRC]),
      .pend     (pend_all[g*N_SRC +: N_SRC]),
      .any_pend (top_id[g])
    );
  end

  icu_regs #(.N_GRP(N_GRP), .N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags_all (flags_all),
    .pend_all  (pend_all),
    .top_id    (top_id),
    .gie       (gie),
    .mask      (mask),
    .vec       (vec),
    .rdata     (reg_rdata)
  );

  icu_req #(.N_GRP(N_GRP)) u_req (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .gie        (gie),
    .mask       (mask),
    .top_id     (top_id),
    .cpu_ack    (cpu_ack),
    .cpu_reti   (cpu_reti),
    .irq_req    (irq_req),
    .in_service (in_service)
  );

  assign irq_vec = vec;
endmodule

// File: rtl/icu_chk.sv
module icu_chk
  import icu_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  localparam int N_GRP = N_MOD + 1,
  localparam int TOT   = N_GRP * N_SRC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TOT-1:0]    src_evt,
  input logic [TOT-1:0]    flags_all,
  input logic              gie,
  input logic [N_GRP-1:0]  mask,
  input logic [N_GRP-1:0]  top_id,
  input logic              in_service,
  input logic              irq_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] irq_vec
);
  // R2: every event pulse leaves its flag set on the next cycle
  assert_flag_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flags_all & $past(src_evt)) == $past(src_evt)));

  // R4: a request only follows a cycle with an open path to the processor
  assert_gated_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie && (|(mask & top_id))));

  // R10: global enable off blocks the request one cycle later
  assert_global_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_req);

  // R9: no request while an interrupt is in service
  assert_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !irq_req);

  // R5: the vector only changes through its own register write
  assert_vector_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_VEC) |=> $stable(irq_vec));

  // R8: the mask only changes through its own register write
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_MASK) |=> $stable(mask));
endmodule

bind hier_int_ctrl icu_chk #(.N_MOD(N_MOD), .N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_evt    (src_evt),
  .flags_all  (flags_all),
  .gie        (gie),
  .mask       (mask),
  .top_id     (top_id),
  .in_service (in_service),
  .irq_req    (irq_req),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .irq_vec    (irq_vec)
);

// File: tb/sim_hier_int_ctrl.sv
module sim_hier_int_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_MOD  = 4;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 16;
  localparam int N_GRP  = N_MOD + 1;
  localparam int TOT    = N_GRP * N_SRC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TOT-1:0]    src_evt = '0;
  logic [TOT-1:0]    src_en = '0;
  logic              reg_we = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              cpu_ack = 1'b0;
  logic              cpu_reti = 1'b0;
  logic              irq_req;
  logic [DATA_W-1:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_int_ctrl #(.N_MOD(N_MOD), .N_SRC(N_SRC), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(logic [TOT-1:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    rd(5'd0, d);  check("R1", "ctrl", d, 0);
    rd(5'd1, d);  check("R1", "mask", d, 0);
    rd(5'd2, d);  check("R1", "vector", d, 0);
    rd(5'd3, d);  check("R1", "top id", d, 0);
    rd(5'd20, d); check("R1", "system flags", d, 0);
    check("R1", "irq_req", irq_req, 0);
    check("R1", "irq_vec", irq_vec, 0);
  endtask

  task automatic t_flag_capture;
    logic [DATA_W-1:0] d;
    pulse_evt(TOT'(1) << 6);           // group 1, source 2, all gates closed
    rd(5'd17, d); check("R2", "flag g1 while disabled", d, 16'h0004);
    rd(5'd9, d);  check("R7", "modid g1 local off", d, 0);
    rd(5'd3, d);  check("R6", "top id local off", d, 0);
    src_en = '1;
    rd(5'd9, d);  check("R7", "modid g1 local on", d, 16'h0004);
    rd(5'd3, d);  check("R6", "top id without mask", d, 16'h0002);
    @(negedge clk);
    @(negedge clk);
    check("R10", "no irq with gates closed", irq_req, 0);
  endtask

  task automatic t_vector;
    logic [DATA_W-1:0] d;
    wr(5'd2, 16'hA55A);
    check("R5", "irq_vec after write", irq_vec, 16'hA55A);
    rd(5'd2, d); check("R5", "vector readback", d, 16'hA55A);
  endtask

  task automatic t_deliver;
    logic [DATA_W-1:0] d;
    wr(5'd1, 16'h0002);
    @(negedge clk);
    check("R10", "mask open, global off", irq_req, 0);
    wr(5'd0, 16'h0001);
    check("R4", "no irq in enabling cycle", irq_req, 0);
    @(negedge clk);
    check("R4", "irq one cycle later", irq_req, 1);
    wr(5'd1, 16'h0001);
    @(negedge clk);
    check("R8", "masked group drops irq", irq_req, 0);
    pulse_evt(TOT'(1) << 16);           // system group, source 0
    @(negedge clk);
    check("R8", "system masked", irq_req, 0);
    wr(5'd1, 16'h0011);
    @(negedge clk);
    check("R8", "multi-group write opens system", irq_req, 1);
    rd(5'd3, d); check("R6", "top id two groups", d, 16'h0012);
    wr(5'd3, 16'h0000);
    rd(5'd3, d); check("R6", "top id write ignored", d, 16'h0012);
  endtask

  task automatic t_service;
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    check("R9", "ack drops irq", irq_req, 0);
    pulse_evt(TOT'(1));                 // group 0 source 0, open path
    @(negedge clk);
    check("R9", "held off in service", irq_req, 0);
    @(negedge clk);
    cpu_reti = 1'b1;
    @(negedge clk);
    cpu_reti = 1'b0;
    check("R9", "re-request after return", irq_req, 1);
  endtask

  task automatic t_clear;
    logic [DATA_W-1:0] d;
    wr(5'd17, 16'h0000);
    rd(5'd17, d); check("R3", "zero write keeps flag", d, 16'h0004);
    wr(5'd17, 16'h0004);
    rd(5'd17, d); check("R3", "w1c clears", d, 0);
    rd(5'd20, d); check("R3", "other group untouched", d, 16'h0001);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 16'h0001;
    src_evt = TOT'(1);
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
    rd(5'd16, d); check("R3", "event beats clear", d, 16'h0001);
    wr(5'd16, 16'h000F);
    wr(5'd20, 16'h000F);
    check("R4", "irq still high in clear cycle", irq_req, 1);
    @(negedge clk);
    check("R4", "irq falls after last clear", irq_req, 0);
  endtask

  task automatic t_global_off;
    pulse_evt(TOT'(1) << 1);            // group 0, source 1
    @(negedge clk);
    check("R4", "pending raises irq", irq_req, 1);
    wr(5'd0, 16'h0000);
    @(negedge clk);
    check("R10", "global off drops irq", irq_req, 0);
    pulse_evt(TOT'(1) << 2);
    @(negedge clk);
    check("R10", "still blocked", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_flag_capture();
    t_vector();
    t_deliver();
    t_service();
    t_clear();
    t_global_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule